// File: doc/BRIEF.md
# SPI Slave Shift Engine

This block is the serial core of an SPI slave. It moves one word of 8 or 16 bits in each direction per transfer. An external master drives the serial clock and the active-low select. The block presents transmit bits on its data output and assembles the bits it receives into a parallel word. The serial pins are brought into the local clock domain through two-stage synchronizers. Serial clock edges are then detected as events of the local clock, so all state is held in ordinary registers clocked by `clk_i`.

The clock idles low. A phase input sets which serial clock edges sample the input and which edges present the next output bit. A bit-order input picks LSB-first or MSB-first for both directions. A width input picks the word length. When a word completes, the assembled word is copied to `rx_word_o` and `rx_full_o` is raised. The flag stays high until the register side pulses `rx_clr_i`. While select stays low, words follow one another back to back. Register decoding and the clock-polarity option are handled outside this block.

Top module: `spi_slv_engine`

## Requirements
- R1: After reset, `sdo_o`, `sdo_oe_o`, `rx_full_o` and all bits of `rx_word_o` are 0.
- R2: A change on `sck_i`, `ss_ni` or `sdi_i` takes effect on the third rising edge of `clk_i` after the change. For example, `sdo_oe_o` rises after the third `clk_i` edge that follows select going low.
- R3: With `cpha_i`=0, the first transmit bit is on `sdo_o` as soon as select is seen low, before any clock edge. Edges 1, 3, 5, ... of the word sample `sdi_i`. Edges 2, 4, ... present the next transmit bit.
- R4: With `cpha_i`=1, `sdo_o` is 0 from select low until the first edge. Edge 1 presents the first transmit bit. Edges 2, 4, ... sample `sdi_i`. Edges 3, 5, ... present the following bits.
- R5: With `lsb_first_i`=1, bit 0 is sent first and the first bit received lands in bit 0. With `lsb_first_i`=0, the top bit of the word (bit 7 or bit 15) is sent first and the first bit received lands in that top bit.
- R6: With `wide_i`=1, a word is 16 bits and takes 32 serial clock edges. With `wide_i`=0, a word is 8 bits and takes 16 edges.
- R7: On the sampling edge that takes the final bit of a word, `rx_word_o` is loaded with the assembled word and `rx_full_o` is set.
- R8: `rx_full_o` stays set through idle time until a one-cycle `rx_clr_i` pulse clears it. A completion in the same cycle as a clear leaves the flag set.
- R9: With `wide_i`=0, only `tx_word_i[7:0]` is sent, and `rx_word_o[15:8]` reads as 0.
- R10: Raising select in the middle of a word turns the output off (`sdo_oe_o`=0, `sdo_o`=0) and drops the partial word without setting `rx_full_o`. The next selection starts again at edge 1.
- R11: While select stays low, the next word follows at once. The next `tx_word_i` is taken on the last edge of the word when `cpha_i`=0, and on the first edge of the new word when `cpha_i`=1.
- R12: Serial clock edges while select is high change neither outputs nor the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from master, idle low |
| ss_ni | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data from master |
| sdo_o | output | 1 | Serial data to master, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the data pin |
| cpha_i | input | 1 | Phase: 0 samples on odd edges, 1 samples on even edges |
| lsb_first_i | input | 1 | Bit order: 1 sends and receives LSB first |
| wide_i | input | 1 | Word length: 1 for 16 bits, 0 for 8 bits |
| tx_word_i | input | 16 | Parallel word to transmit |
| rx_word_o | output | 16 | Last complete received word |
| rx_full_o | output | 1 | Received word ready |
| rx_clr_i | input | 1 | One-cycle pulse that clears `rx_full_o` |

## Verification
The assertions assume that `cpha_i`, `lsb_first_i` and `wide_i` change only while select is high. They also assume that a serial clock level is held for at least three local clock cycles, so the synchronizer sees every edge and `sdi_i` is steady when it is sampled. The stimulus holds each serial clock half-period for six local cycles. It changes the configuration only between selections, and it changes `sdi_i` only well before the edge that samples it. `tx_word_i` is changed only after its load edge has passed, so each word loads the value the checks expect.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic sck;
    logic ss_n;
    logic sdi;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, ss_n: 1'b1, sdi: 1'b0};
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[0] <= RST_VAL;
        else         stage_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else         stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_slv_seq.sv
module spi_slv_seq #(
  parameter int DW = 16,
  parameter int HW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic ss_s_i,
  input  logic cpha_i,
  input  logic wide_i,
  output logic active_o,
  output logic load_o,
  output logic pop_o,
  output logic zero_o,
  output logic capture_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(2*DW) + 1;
  localparam logic [CNT_W-1:0] EDGES_WIDE   = CNT_W'(2*DW);
  localparam logic [CNT_W-1:0] EDGES_NARROW = CNT_W'(2*HW);

  logic             sck_q, ss_q;
  logic [CNT_W-1:0] cnt_q, k, n_edges;
  logic             sck_edge, ss_fall, step, last_edge, sample_edge, launch, word_start;

  always_comb begin
    active_o    = ~ss_s_i;
    sck_edge    = sck_s_i ^ sck_q;
    ss_fall     = ss_q & ~ss_s_i;
    step        = active_o & ~ss_fall & sck_edge;
    k           = cnt_q + CNT_W'(1);           // 1-based index of this edge
    n_edges     = wide_i ? EDGES_WIDE : EDGES_NARROW;
    last_edge   = (k >= n_edges);
    sample_edge = k[0] ^ cpha_i;               // phase 0: odd edges sample
    capture_o   = step & sample_edge;
    launch      = step & ~sample_edge;
    done_o      = capture_o & (cpha_i ? last_edge : (k == n_edges - CNT_W'(1)));
    word_start  = cpha_i ? (k == CNT_W'(1)) : last_edge;
    load_o      = (ss_fall & ~cpha_i) | (launch & word_start);
    pop_o       = launch & ~word_start;
    zero_o      = ss_fall & cpha_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      sck_q <= sck_s_i;
      ss_q  <= ss_s_i;
      if (!active_o || ss_fall) cnt_q <= '0;
      else if (step)            cnt_q <= last_edge ? '0 : k;
    end
  end
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
  parameter int DW = 16,
  parameter int HW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          lsb_first_i,
  input  logic [DW-1:0] tx_word_i,
  input  logic          sdi_s_i,
  input  logic          active_i,
  input  logic          load_i,
  input  logic          pop_i,
  input  logic          zero_i,
  input  logic          capture_i,
  input  logic          done_i,
  input  logic          rx_clr_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [DW-1:0] rx_word_o,
  output logic          rx_full_o
);
  localparam int PAD = DW - HW;

  logic [DW-1:0] tx_q, tx_src, rx_q, rx_next, rx_fmt;
  logic          sdo_q, oe_q, head;

  always_comb begin
    tx_src  = load_i ? (wide_i ? tx_word_i : {{PAD{1'b0}}, tx_word_i[HW-1:0]}) : tx_q;
    head    = lsb_first_i ? tx_src[0] : (wide_i ? tx_src[DW-1] : tx_src[HW-1]);
    rx_next = lsb_first_i ? {sdi_s_i, rx_q[DW-1:1]} : {rx_q[DW-2:0], sdi_s_i};
    if (wide_i)           rx_fmt = rx_next;
    else if (lsb_first_i) rx_fmt = {{PAD{1'b0}}, rx_next[DW-1 -: HW]};
    else                  rx_fmt = {{PAD{1'b0}}, rx_next[HW-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
      rx_q      <= '0;
      rx_word_o <= '0;
      rx_full_o <= 1'b0;
    end else begin
      oe_q <= active_i;
      if (zero_i) begin
        sdo_q <= 1'b0;
      end else if (load_i || pop_i) begin
        sdo_q <= head;
        tx_q  <= lsb_first_i ? (tx_src >> 1) : (tx_src << 1);
      end
      if (capture_i) rx_q <= rx_next;
      if (done_i) begin
        rx_word_o <= rx_fmt;
        rx_full_o <= 1'b1;
      end else if (rx_clr_i) begin
        rx_full_o <= 1'b0;
      end
    end
  end

  assign sdo_oe_o = oe_q;
  assign sdo_o    = oe_q & sdo_q;

  p_set_on_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rx_full_o);
  p_full_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o && !rx_clr_i |=> rx_full_o);
  p_narrow_high_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !wide_i |=> rx_word_o[DW-1:HW] == '0);
endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
  import spi_slv_pkg::*;
#(
  parameter int DW = 16,
  parameter int HW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          ss_ni,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  input  logic          cpha_i,
  input  logic          lsb_first_i,
  input  logic          wide_i,
  input  logic [DW-1:0] tx_word_i,
  output logic [DW-1:0] rx_word_o,
  output logic          rx_full_o,
  input  logic          rx_clr_i
);
  spi_pins_t pins_raw, pins_s;
  logic      active, load, pop, zero, capture, done;

  assign pins_raw = '{sck: sck_i, ss_n: ss_ni, sdi: sdi_i};

  spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  spi_slv_seq #(.DW(DW), .HW(HW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (pins_s.sck),
    .ss_s_i    (pins_s.ss_n),
    .cpha_i    (cpha_i),
    .wide_i    (wide_i),
    .active_o  (active),
    .load_o    (load),
    .pop_o     (pop),
    .zero_o    (zero),
    .capture_o (capture),
    .done_o    (done)
  );

  spi_slv_shift #(.DW(DW), .HW(HW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wide_i      (wide_i),
    .lsb_first_i (lsb_first_i),
    .tx_word_i   (tx_word_i),
    .sdi_s_i     (pins_s.sdi),
    .active_i    (active),
    .load_i      (load),
    .pop_i       (pop),
    .zero_i      (zero),
    .capture_i   (capture),
    .done_i      (done),
    .rx_clr_i    (rx_clr_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .rx_word_o   (rx_word_o),
    .rx_full_o   (rx_full_o)
  );

  // deselect seen by the engine silences the pin on the next cycle
  p_quiet_when_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s.ss_n |=> !sdo_oe_o && !sdo_o);
endmodule

// File: tb/spi_slv_engine_tb_top.sv
module spi_slv_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
  logic        cpha = 1'b0, lsb = 1'b0, wide = 1'b0, rx_clr = 1'b0;
  logic [15:0] tx_word = '0;
  logic        sdo, sdo_oe, rx_full;
  logic [15:0] rx_word;

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slv_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ss_ni(ss_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cpha_i(cpha), .lsb_first_i(lsb),
    .wide_i(wide), .tx_word_i(tx_word), .rx_word_o(rx_word),
    .rx_full_o(rx_full), .rx_clr_i(rx_clr)
  );

  // ---------------- behavioural reference model ----------------
  logic        h0s = 0, h1s = 0, h2s = 0, h0c = 1, h1c = 1, h2c = 1, h0d = 0, h1d = 0;
  int          m_cnt = 0;
  bit          m_oe = 0, m_out = 0, m_full = 0;
  logic [15:0] m_word = '0;
  bit          txq[$];
  bit          rxq[$];

  function automatic void m_load();
    int n = wide ? 16 : 8;
    txq.delete();
    for (int i = 0; i < n; i++) txq.push_back(lsb ? tx_word[i] : tx_word[n-1-i]);
    m_out = txq.pop_front();
  endfunction

  function automatic void m_pop();
    m_out = (txq.size() > 0) ? txq.pop_front() : 1'b0;
  endfunction

  always @(posedge clk) begin : model
    int  k, n;
    bit  done, cap;
    logic [15:0] w;
    if (!rst_n) begin
      h0s = 0; h1s = 0; h2s = 0; h0c = 1; h1c = 1; h2c = 1; h0d = 0; h1d = 0;
      m_cnt = 0; m_oe = 0; m_out = 0; m_full = 0; m_word = '0;
      txq.delete(); rxq.delete();
    end else begin
      done = 0;
      n = wide ? 16 : 8;
      if (h1c) begin
        m_oe = 0; m_cnt = 0; rxq.delete();
      end else begin
        m_oe = 1;
        if (h2c) begin
          m_cnt = 0;
          if (!cpha) m_load(); else m_out = 0;
        end else if (h1s != h2s) begin
          k = m_cnt + 1;
          cap = ((k % 2) == 1) ^ cpha;
          if (cap) begin
            rxq.push_back(h1d);
            if (k == 2*n - 1 + int'(cpha)) begin
              w = '0;
              foreach (rxq[i]) w[lsb ? i : n-1-i] = rxq[i];
              m_word = w; done = 1; rxq.delete();
            end
          end else begin
            if (cpha ? (k == 1) : (k == 2*n)) m_load(); else m_pop();
          end
          m_cnt = (k == 2*n) ? 0 : k;
        end
      end
      if (done) m_full = 1;
      else if (rx_clr) m_full = 0;
      h2s = h1s; h1s = h0s; h0s = sck;
      h2c = h1c; h1c = h0c; h0c = ss_n;
      h1d = h0d; h0d = sdi;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (sdo !== (m_oe & m_out) || sdo_oe !== m_oe || rx_word !== m_word || rx_full !== m_full) begin
        errors++;
        $display("FAIL %s per-clock: sdo=%b oe=%b word=%h full=%b expected sdo=%b oe=%b word=%h full=%b",
                 tag, sdo, sdo_oe, rx_word, rx_full, m_oe & m_out, m_oe, m_word, m_full);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); rx_clr = 1'b1;
    @(negedge clk); rx_clr = 1'b0;
  endtask

  task automatic xfer(input string rq, input bit ph, input bit lf, input bit wd, input int nw,
                      input logic [15:0] tx0, input logic [15:0] tx1,
                      input logic [15:0] d0, input logic [15:0] d1);
    int n = wd ? 16 : 8;
    logic [15:0] mask = wd ? 16'hFFFF : 16'h00FF;
    @(negedge clk);
    tag = rq; cpha = ph; lsb = lf; wide = wd; tx_word = tx0;
    wait_n(2);
    ss_n = 1'b0;
    wait_n(4);
    for (int j = 0; j < nw; j++) begin
      logic [15:0] d = (j == 0) ? d0 : d1;
      logic [15:0] tx_exp = ((j == 0) ? tx0 : tx1) & mask;
      logic [15:0] got = '0;
      for (int k = 1; k <= 2*n; k++) begin
        bit cap = ((k % 2) == 1) ^ ph;
        int i = (k - 1) / 2;
        if (cap) sdi = lf ? d[i] : d[n-1-i];
        wait_n(SCK_HALF);
        if (cap) got[lf ? i : n-1-i] = sdo;
        sck = ~sck;
        if (k == 2 && j + 1 < nw) tx_word = tx1;
      end
      wait_n(4);
      chk({rq, " rx word"}, rx_word, d & mask);
      chk({rq, " tx bits on sdo"}, got, tx_exp);
      chk("R7 full after word", {15'd0, rx_full}, 16'd1);
      if (!wd) chk("R9 high byte zero", {8'd0, rx_word[15:8]}, 16'd0);
    end
    ss_n = 1'b1;
    wait_n(6);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    wait_n(3);
    chk("R1 reset sdo", {15'd0, sdo}, 16'd0);
    chk("R1 reset oe", {15'd0, sdo_oe}, 16'd0);
    chk("R1 reset full", {15'd0, rx_full}, 16'd0);
    chk("R1 reset word", rx_word, 16'd0);
    rst_n = 1'b1;
    wait_n(4);

    // R2: select seen on third rising edge
    tag = "R2";
    @(negedge clk); ss_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R2 oe before third edge", {15'd0, sdo_oe}, 16'd0);
    @(posedge clk); #1;
    chk("R2 oe after third edge", {15'd0, sdo_oe}, 16'd1);
    @(negedge clk); ss_n = 1'b1;
    wait_n(6);

    xfer("R3", 1'b0, 1'b0, 1'b0, 1, 16'hA53C, 16'h0, 16'h5AC3, 16'h0);
    pulse_clr();
    xfer("R4", 1'b1, 1'b1, 1'b1, 1, 16'h1234, 16'h0, 16'hBEEF, 16'h0);
    pulse_clr();
    xfer("R5", 1'b0, 1'b1, 1'b1, 1, 16'h8001, 16'h0, 16'h7FFE, 16'h0);
    pulse_clr();
    xfer("R6", 1'b1, 1'b0, 1'b0, 1, 16'hFF5A, 16'h0, 16'h0096, 16'h0);

    // R8: flag held through idle, then cleared
    tag = "R8";
    wait_n(20);
    chk("R8 full held", {15'd0, rx_full}, 16'd1);
    pulse_clr();
    chk("R8 full cleared", {15'd0, rx_full}, 16'd0);

    // R10: deselect mid-word
    tag = "R10";
    @(negedge clk); cpha = 1'b0; lsb = 1'b0; wide = 1'b0; tx_word = 16'h00FF; sdi = 1'b1;
    ss_n = 1'b0;
    wait_n(4);
    for (int k = 0; k < 5; k++) begin wait_n(SCK_HALF); sck = ~sck; end
    wait_n(2);
    ss_n = 1'b1;
    wait_n(5);
    chk("R10 oe off", {15'd0, sdo_oe}, 16'd0);
    chk("R10 sdo low", {15'd0, sdo}, 16'd0);
    chk("R10 no partial word", {15'd0, rx_full}, 16'd0);

    // R12: edges while deselected
    tag = "R12";
    for (int k = 0; k < 9; k++) begin wait_n(SCK_HALF); sck = ~sck; end
    wait_n(5);
    chk("R12 full unchanged", {15'd0, rx_full}, 16'd0);
    chk("R12 word unchanged", rx_word, 16'h0096);
    chk("R12 oe off", {15'd0, sdo_oe}, 16'd0);

    xfer("R10", 1'b1, 1'b0, 1'b1, 1, 16'hC0DE, 16'h0, 16'h3A5C, 16'h0);
    pulse_clr();
    xfer("R11", 1'b0, 1'b0, 1'b0, 2, 16'h0081, 16'h0042, 16'h00E7, 16'h0018);
    pulse_clr();
    xfer("R11", 1'b1, 1'b1, 1'b1, 2, 16'hF00D, 16'h0BAD, 16'h1357, 16'h9BDF);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule